// File: doc/BRIEF.md
# Dual-Address I2C Target Front-End

This block is an I2C bus target that answers two fixed 7-bit device addresses on one shared bus. It oversamples SCL and SDA with the system clock, recognises START, repeated START and STOP, and moves bytes MSB first with a ninth acknowledge clock. One address reaches a small register file through a one-byte pointer. The other reaches a larger byte memory through a two-byte pointer that is sent high byte first.

Each target keeps its own pointer. A write transfer first loads the pointer and then stores any number of data bytes, and the pointer advances after each one. A read transfer streams bytes from the pointer for as long as the controller acknowledges. Toward storage the block has plain synchronous ports: a single-cycle write strobe, and a read strobe whose data is expected on the cycle after it. SDA is open-drain. The block drives an output-enable, and a 1 pulls the line low.

Top module: `i2c_dual_target`

## Requirements
- R1: After reset `sda_oe` is 0 and all four storage strobes are 0.
- R2: An address byte is acknowledged (SDA low through the ninth clock) only for device address 0x68 (register target) or 0x50 (memory target), with bit 0 as R/W and 0 meaning write. Any other address is not acknowledged, and the bytes that follow it up to the next START cause no write. During a read of a foreign address the line stays released, so it reads as 0xFF.
- R3: A write to 0x68 takes one pointer byte, and each later data byte gives one `reg_wr_en` pulse at the current pointer. Every data byte is acknowledged. A transfer with zero data bytes only sets the pointer.
- R4: A write to 0x50 takes two pointer bytes, high byte first, and the pointer keeps their low MEM_AW bits. Each later data byte gives one `mem_wr_en` pulse and is acknowledged.
- R5: A read returns the byte stored at the pointer and keeps sending bytes while the controller acknowledges. After a NACK the block releases SDA and sends nothing more.
- R6: The active pointer advances by one after each byte written or sent. The register pointer wraps from 2^REG_AW-1 to 0, and the memory pointer wraps from 2^MEM_AW-1 to 0.
- R7: The two pointers are independent. Traffic to one target leaves the other target's pointer unchanged, and at most one storage strobe is active in any cycle.
- R8: A repeated START ends the current transfer and starts a new address phase. A read after it begins at the pointer that was just set.
- R9: A memory write that stops after only the high pointer byte leaves the stored memory pointer unchanged.
- R10: `sda_oe` changes only while SCL is low. It never changes once SCL has been high for several system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed SCL line |
| sda_i | input | 1 | Sensed SDA line |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_addr | output | REG_AW | Register file address (register pointer) |
| reg_wr_en | output | 1 | Register write strobe |
| reg_rd_en | output | 1 | Register read strobe; data due next cycle |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data |
| mem_addr | output | MEM_AW | Memory address (memory pointer) |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_rd_en | output | 1 | Memory read strobe; data due next cycle |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |

## Verification
The hardest state to reach is a pointer that holds a stale or half-loaded value. One case is a memory write cut off after its high pointer byte. Another is a read with no pointer phase, issued right after traffic to the other target. The bench builds these with directed transfers that stop early, that omit the pointer, or that switch targets between a write and a pointer-less read. It then checks the returned bytes against shadow copies whose pointers it advances on its own. Random transfers with pointers near both wrap points, and random lengths, repeat this across both targets.

// File: rtl/i2c_dt_pkg.sv
package i2c_dt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR_HI,
        ST_PTR_LO,
        ST_WRITE,
        ST_READ
    } dt_state_e;

    typedef enum logic [0:0] {
        TGT_REG,
        TGT_MEM
    } dt_target_e;

    // bus events derived from synchronized lines
    typedef struct packed {
        logic sda;
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
    } dt_bus_ev_t;

    typedef struct packed {
        dt_state_e  st;
        dt_state_e  nxt;
        dt_target_e tgt;
        logic       in_ack;
        logic       acked;
        logic [3:0] cnt;
        logic [7:0] sh;
        logic [7:0] hi;
        logic       oe;
        logic       fetch;
    } dt_fsm_t;

endpackage

// File: rtl/i2c_dt_linesync.sv
module i2c_dt_linesync
    import i2c_dt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output dt_bus_ev_t ev_o
);

    typedef struct packed {
        logic [1:0] scl_ff;
        logic [1:0] sda_ff;
        logic       scl_p;
        logic       sda_p;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d        = q;
        d.scl_ff = {q.scl_ff[0], scl_i};
        d.sda_ff = {q.sda_ff[0], sda_i};
        d.scl_p  = q.scl_ff[1];
        d.sda_p  = q.sda_ff[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{scl_ff: 2'b11, sda_ff: 2'b11, scl_p: 1'b1, sda_p: 1'b1};
        end else begin
            q <= d;
        end
    end

    logic scl_s, sda_s;
    assign scl_s = q.scl_ff[1];
    assign sda_s = q.sda_ff[1];

    always_comb begin
        ev_o.sda      = sda_s;
        ev_o.start    = scl_s & q.scl_p & q.sda_p & ~sda_s;
        ev_o.stop     = scl_s & q.scl_p & ~q.sda_p & sda_s;
        ev_o.scl_rise = scl_s & ~q.scl_p;
        ev_o.scl_fall = ~scl_s & q.scl_p;
    end

endmodule

// File: rtl/i2c_dt_ptr.sv
module i2c_dt_ptr #(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc,
    output logic [AW-1:0] ptr_o
);

    localparam logic [AW-1:0] STEP = AW'(1);

    logic [AW-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (load) begin
            ptr_d = load_val;
        end else if (inc) begin
            ptr_d = ptr_q + STEP;   // natural wrap at 2^AW
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign ptr_o = ptr_q;

endmodule

// File: rtl/i2c_dual_target.sv
module i2c_dual_target
    import i2c_dt_pkg::*;
#(
    parameter int         REG_AW  = 5,
    parameter int         MEM_AW  = 12,
    parameter logic [6:0] REG_DEV = 7'h68,
    parameter logic [6:0] MEM_DEV = 7'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [REG_AW-1:0] reg_addr,
    output logic              reg_wr_en,
    output logic              reg_rd_en,
    output logic [7:0]        reg_wdata,
    input  logic [7:0]        reg_rdata,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              mem_wr_en,
    output logic              mem_rd_en,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);

    localparam int         PTR_W   = 16;
    localparam logic [3:0] RX_FULL = 4'd8;
    localparam logic [3:0] TX_LAST = 4'd7;
    localparam logic [3:0] ONE     = 4'd1;

    dt_bus_ev_t ev;
    dt_fsm_t    d, q;

    logic             ld_reg, ld_mem, inc_reg, inc_mem;
    logic             hit_reg, hit_mem;
    logic [PTR_W-1:0] ptr16;
    logic             unused_ptr_bits;

    assign ptr16           = {q.hi, q.sh};
    assign unused_ptr_bits = ^ptr16;

    i2c_dt_linesync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    i2c_dt_ptr #(.AW(REG_AW)) u_reg_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld_reg),
        .load_val (q.sh[REG_AW-1:0]),
        .inc      (inc_reg),
        .ptr_o    (reg_addr)
    );

    i2c_dt_ptr #(.AW(MEM_AW)) u_mem_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld_mem),
        .load_val (ptr16[MEM_AW-1:0]),
        .inc      (inc_mem),
        .ptr_o    (mem_addr)
    );

    assign hit_reg = (q.sh[7:1] == REG_DEV);
    assign hit_mem = (q.sh[7:1] == MEM_DEV);

    always_comb begin
        d         = q;
        d.fetch   = 1'b0;
        ld_reg    = 1'b0;
        ld_mem    = 1'b0;
        inc_reg   = 1'b0;
        inc_mem   = 1'b0;
        reg_wr_en = 1'b0;
        mem_wr_en = 1'b0;
        reg_rd_en = 1'b0;
        mem_rd_en = 1'b0;

        // storage answers one cycle after a read strobe
        if (q.fetch) begin
            d.sh = (q.tgt == TGT_REG) ? reg_rdata : mem_rdata;
        end

        if (ev.stop) begin
            d.st     = ST_IDLE;
            d.oe     = 1'b0;
            d.in_ack = 1'b0;
        end else if (ev.start) begin
            d.st     = ST_ADDR;
            d.cnt    = '0;
            d.oe     = 1'b0;
            d.in_ack = 1'b0;
        end else begin
            unique case (q.st)
                ST_IDLE: ;

                ST_ADDR, ST_PTR_HI, ST_PTR_LO, ST_WRITE: begin
                    if (!q.in_ack) begin
                        if (ev.scl_rise && q.cnt != RX_FULL) begin
                            d.sh  = {q.sh[6:0], ev.sda};
                            d.cnt = q.cnt + ONE;
                        end else if (ev.scl_fall && q.cnt == RX_FULL) begin
                            d.cnt = '0;
                            unique case (q.st)
                                ST_ADDR: begin
                                    if (hit_reg || hit_mem) begin
                                        d.tgt    = hit_reg ? TGT_REG : TGT_MEM;
                                        d.in_ack = 1'b1;
                                        d.oe     = 1'b1;
                                        if (q.sh[0]) begin
                                            d.nxt   = ST_READ;
                                            d.fetch = 1'b1;
                                            if (hit_reg) begin
                                                reg_rd_en = 1'b1;
                                                inc_reg   = 1'b1;
                                            end else begin
                                                mem_rd_en = 1'b1;
                                                inc_mem   = 1'b1;
                                            end
                                        end else begin
                                            d.nxt = hit_reg ? ST_PTR_LO : ST_PTR_HI;
                                        end
                                    end else begin
                                        d.st = ST_IDLE;
                                    end
                                end
                                ST_PTR_HI: begin
                                    d.hi     = q.sh;
                                    d.in_ack = 1'b1;
                                    d.oe     = 1'b1;
                                    d.nxt    = ST_PTR_LO;
                                end
                                ST_PTR_LO: begin
                                    if (q.tgt == TGT_REG) begin
                                        ld_reg = 1'b1;
                                    end else begin
                                        ld_mem = 1'b1;
                                    end
                                    d.in_ack = 1'b1;
                                    d.oe     = 1'b1;
                                    d.nxt    = ST_WRITE;
                                end
                                default: begin
                                    if (q.tgt == TGT_REG) begin
                                        reg_wr_en = 1'b1;
                                        inc_reg   = 1'b1;
                                    end else begin
                                        mem_wr_en = 1'b1;
                                        inc_mem   = 1'b1;
                                    end
                                    d.in_ack = 1'b1;
                                    d.oe     = 1'b1;
                                    d.nxt    = ST_WRITE;
                                end
                            endcase
                        end
                    end else if (ev.scl_fall) begin
                        // end of the ninth clock
                        d.in_ack = 1'b0;
                        d.cnt    = '0;
                        d.st     = q.nxt;
                        d.oe     = (q.nxt == ST_READ) ? ~q.sh[7] : 1'b0;
                    end
                end

                ST_READ: begin
                    if (!q.in_ack) begin
                        if (ev.scl_fall) begin
                            if (q.cnt == TX_LAST) begin
                                d.oe     = 1'b0;
                                d.in_ack = 1'b1;
                            end else begin
                                d.cnt = q.cnt + ONE;
                                d.sh  = {q.sh[6:0], 1'b0};
                                d.oe  = ~q.sh[6];
                            end
                        end
                    end else begin
                        if (ev.scl_rise) begin
                            d.acked = ~ev.sda;
                            if (!ev.sda) begin
                                d.fetch = 1'b1;
                                if (q.tgt == TGT_REG) begin
                                    reg_rd_en = 1'b1;
                                    inc_reg   = 1'b1;
                                end else begin
                                    mem_rd_en = 1'b1;
                                    inc_mem   = 1'b1;
                                end
                            end
                        end else if (ev.scl_fall) begin
                            d.in_ack = 1'b0;
                            d.cnt    = '0;
                            if (q.acked) begin
                                d.oe = ~q.sh[7];
                            end else begin
                                d.st = ST_IDLE;
                                d.oe = 1'b0;
                            end
                        end
                    end
                end

                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, nxt: ST_IDLE, tgt: TGT_REG, in_ack: 1'b0,
                   acked: 1'b0, cnt: 4'd0, sh: 8'h00, hi: 8'h00,
                   oe: 1'b0, fetch: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe    = q.oe;
    assign reg_wdata = q.sh;
    assign mem_wdata = q.sh;

endmodule

// File: rtl/i2c_dt_checker.sv
module i2c_dt_checker #(
    parameter int REG_AW = 5,
    parameter int MEM_AW = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe,
    input logic [REG_AW-1:0] reg_addr,
    input logic              reg_wr_en,
    input logic              reg_rd_en,
    input logic [MEM_AW-1:0] mem_addr,
    input logic              mem_wr_en,
    input logic              mem_rd_en
);

    AST_OE_STILL_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i) && $past(scl_i, 2) && $past(scl_i, 3)) |-> $stable(sda_oe)); // R10

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_wr_en, reg_rd_en, mem_wr_en, mem_rd_en})); // R7

    AST_REG_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en); // R3

    AST_MEM_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> !mem_wr_en); // R4

    AST_REG_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en || reg_rd_en) |=> (reg_addr == REG_AW'($past(reg_addr) + 1'b1))); // R6

    AST_MEM_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en || mem_rd_en) |=> (mem_addr == MEM_AW'($past(mem_addr) + 1'b1))); // R6

    AST_REG_PTR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en || mem_rd_en) |=> $stable(reg_addr)); // R7

endmodule

bind i2c_dual_target i2c_dt_checker #(.REG_AW(REG_AW), .MEM_AW(MEM_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .reg_addr  (reg_addr),
    .reg_wr_en (reg_wr_en),
    .reg_rd_en (reg_rd_en),
    .mem_addr  (mem_addr),
    .mem_wr_en (mem_wr_en),
    .mem_rd_en (mem_rd_en)
);

// File: tb/tb_i2c_dual_target.sv
module tb_i2c_dual_target;

    localparam int         REG_AW  = 5;
    localparam int         MEM_AW  = 12;
    localparam int         REG_N   = 1 << REG_AW;
    localparam int         MEM_N   = 1 << MEM_AW;
    localparam int         Q       = 8;
    localparam logic [6:0] REG_DEV = 7'h68;
    localparam logic [6:0] MEM_DEV = 7'h50;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_oe;
    logic [REG_AW-1:0] reg_addr;
    logic [MEM_AW-1:0] mem_addr;
    logic reg_wr_en, reg_rd_en, mem_wr_en, mem_rd_en;
    logic [7:0] reg_wdata, mem_wdata;
    logic [7:0] reg_rdata = 8'h00;
    logic [7:0] mem_rdata = 8'h00;

    assign sda_line = sda_m & ~sda_oe;

    i2c_dual_target #(.REG_AW(REG_AW), .MEM_AW(MEM_AW), .REG_DEV(REG_DEV), .MEM_DEV(MEM_DEV)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_addr(mem_addr), .mem_wr_en(mem_wr_en), .mem_rd_en(mem_rd_en),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] init_reg(int i);
        return 8'(i * 7 + 3);
    endfunction

    function automatic logic [7:0] init_mem(int i);
        return 8'((i * 13) ^ 8'h5A);
    endfunction

    // storage models driven by the design's strobes
    logic [7:0] reg_m [REG_N];
    logic [7:0] mem_m [MEM_N];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_N; i++) reg_m[i] <= init_reg(i);
            for (int i = 0; i < MEM_N; i++) mem_m[i] <= init_mem(i);
        end else begin
            if (reg_wr_en) reg_m[reg_addr] <= reg_wdata;
            if (reg_rd_en) reg_rdata <= reg_m[reg_addr];
            if (mem_wr_en) mem_m[mem_addr] <= mem_wdata;
            if (mem_rd_en) mem_rdata <= mem_m[mem_addr];
        end
    end

    // shadow contents and pointers computed from the requirements
    logic [7:0] exp_reg [REG_N];
    logic [7:0] exp_mem [MEM_N];
    int exp_rptr = 0;
    int exp_mptr = 0;

    int n_cmp = 0;
    int n_mis = 0;
    int wr_cnt = 0;
    int oe_bad = 0;
    int hi_cnt = 0;
    logic prev_oe = 1'b0;
    bit done = 0;

    always @(posedge clk) begin
        if (rst_n) begin
            if (reg_wr_en || mem_wr_en) wr_cnt <= wr_cnt + 1;
            if (hi_cnt >= 4 && scl_m && sda_oe != prev_oe) oe_bad <= oe_bad + 1;
            hi_cnt  <= scl_m ? ((hi_cnt < 16) ? hi_cnt + 1 : hi_cnt) : 0;
            prev_oe <= sda_oe;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_mis++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic i2c_rstart();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq(); wq();
    endtask

    task automatic send(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq();
            scl_m = 1'b1; wq(); wq();
            scl_m = 1'b0; wq();
        end
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        ack = ~sda_line; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic recv(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq();
            scl_m = 1'b1; wq();
            b[i] = sda_line; wq();
            scl_m = 1'b0;
        end
        wq();
        sda_m = give_ack ? 1'b0 : 1'b1; wq();
        scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0; wq();
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] pat(logic [7:0] base, int k);
        return base ^ 8'(k * 17);
    endfunction

    task automatic do_write(input bit mem, input int ptr, input int n,
                            input logic [7:0] base, input string req);
        bit ack;
        logic [6:0] dev;
        dev = mem ? MEM_DEV : REG_DEV;
        i2c_start();
        send({dev, 1'b0}, ack); chk({req, " addr ack"}, ack, 1);
        if (mem) begin
            send(ptr[15:8], ack); chk({req, " ptr hi ack"}, ack, 1);
        end
        send(ptr[7:0], ack); chk({req, " ptr ack"}, ack, 1);
        if (mem) exp_mptr = ptr & (MEM_N - 1);
        else     exp_rptr = ptr & (REG_N - 1);
        for (int k = 0; k < n; k++) begin
            send(pat(base, k), ack); chk({req, " data ack"}, ack, 1);
            if (mem) begin
                exp_mem[exp_mptr] = pat(base, k);
                exp_mptr = (exp_mptr + 1) & (MEM_N - 1);
            end else begin
                exp_reg[exp_rptr] = pat(base, k);
                exp_rptr = (exp_rptr + 1) & (REG_N - 1);
            end
        end
        i2c_stop();
    endtask

    task automatic do_read(input bit mem, input bit set_ptr, input int ptr,
                           input int n, input string req);
        bit ack;
        logic [7:0] b;
        logic [6:0] dev;
        int e;
        dev = mem ? MEM_DEV : REG_DEV;
        i2c_start();
        if (set_ptr) begin
            send({dev, 1'b0}, ack); chk({req, " addr ack"}, ack, 1);
            if (mem) send(ptr[15:8], ack);
            send(ptr[7:0], ack); chk({req, " ptr ack"}, ack, 1);
            if (mem) exp_mptr = ptr & (MEM_N - 1);
            else     exp_rptr = ptr & (REG_N - 1);
            i2c_rstart();   // R8
        end
        send({dev, 1'b1}, ack); chk({req, " read addr ack"}, ack, 1);
        for (int k = 0; k < n; k++) begin
            recv(k != n - 1, b);
            if (mem) begin
                e = exp_mem[exp_mptr];
                exp_mptr = (exp_mptr + 1) & (MEM_N - 1);
            end else begin
                e = exp_reg[exp_rptr];
                exp_rptr = (exp_rptr + 1) & (REG_N - 1);
            end
            chk({req, " read data"}, b, e);
        end
        repeat (4) @(negedge clk);
        chk("R5 release after NACK", sda_oe, 0);
        i2c_stop();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_mis++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        bit ack;
        logic [7:0] b;
        int w0;
        void'($urandom(32'd2024));
        for (int i = 0; i < REG_N; i++) exp_reg[i] = init_reg(i);
        for (int i = 0; i < MEM_N; i++) exp_mem[i] = init_mem(i);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset state
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 strobes", {reg_wr_en, reg_rd_en, mem_wr_en, mem_rd_en}, 0);

        // R3 register write with one pointer byte
        do_write(0, 3, 3, 8'hA1, "R3");
        // R4 memory write with two pointer bytes
        do_write(1, 16'h0123, 2, 8'h11, "R4");

        // R2 foreign address: no ack, following bytes ignored
        w0 = wr_cnt;
        i2c_start();
        send(8'hA2, ack); chk("R2 foreign write ack", ack, 0);
        send(8'h00, ack);
        send(8'h55, ack);
        i2c_stop();
        chk("R2 no write after foreign address", wr_cnt, w0);
        i2c_start();
        send(8'hA3, ack); chk("R2 foreign read ack", ack, 0);
        recv(0, b); chk("R2 foreign read line released", b, 8'hFF);
        i2c_stop();

        // R8 read after repeated START uses the fresh pointer; R5 streaming
        do_read(0, 1, 3, 3, "R8");

        // R6 wrap on both targets; R4 upper pointer bits dropped
        do_write(0, 31, 2, 8'h5A, "R6");
        do_read(0, 1, 31, 2, "R6");
        do_write(1, 16'hFFFF, 2, 8'hC1, "R6");
        do_read(1, 1, 16'h0FFF, 2, "R6");

        // R7 separate pointers
        do_write(0, 10, 1, 8'h77, "R7");
        do_write(1, 16'h0200, 3, 8'h3C, "R7");
        do_read(0, 0, 0, 2, "R7");

        // R9 partial pointer leaves memory pointer unchanged
        i2c_start();
        send({MEM_DEV, 1'b0}, ack); chk("R9 addr ack", ack, 1);
        send(8'h0A, ack);
        i2c_stop();
        do_read(1, 0, 0, 1, "R9");

        // R3 zero data bytes only sets the pointer
        do_write(0, 20, 0, 8'h00, "R3");
        do_read(0, 0, 0, 1, "R3");

        // random mix
        for (int t = 0; t < 20; t++) begin
            bit mem;
            int ptr, n;
            mem = 1'($urandom % 2);
            ptr = ($urandom % 2) ? int'($urandom % 65536)
                                 : (mem ? MEM_N - 1 - int'($urandom % 2) : REG_N - 1 - int'($urandom % 2));
            n   = 1 + int'($urandom % 4);
            if ($urandom % 2) do_write(mem, ptr, n, 8'($urandom), mem ? "R4" : "R3");
            else              do_read(mem, 1'($urandom % 2), ptr, n, "R5");
        end

        // final contents
        w0 = 0;
        for (int i = 0; i < REG_N; i++) if (reg_m[i] != exp_reg[i]) w0++;
        chk("R3 register contents mismatches", w0, 0);
        w0 = 0;
        for (int i = 0; i < MEM_N; i++) if (mem_m[i] != exp_mem[i]) w0++;
        chk("R4 memory contents mismatches", w0, 0);
        chk("R10 sda_oe changes while SCL high", oe_bad, 0);

        finish_run();
    end

endmodule